// File: doc/BRIEF.md
# Heartbeat Supervisor with Reset Generator

This block watches a heartbeat line that a managed processor toggles while it is running properly, at a nominal rate of roughly 750 Hz. It flags two kinds of fault. The first is a timeout: the line stops toggling for longer than a programmable limit. The intended setting is a limit equal to 200 ms of clock cycles. The second is a glitch: two heartbeat edges that come closer together than a programmable minimum spacing. Both the rising and the falling edge of the heartbeat are timed. The input passes through a synchronizer first, and one interval counter restarts on every synchronized edge.

When a fault is found, the block drives an active-low reset output. The pulse lasts a programmable number of cycles, never fewer than one, and the limit should be set to at least 1 ms of cycles. After the pulse the block enters a grace window as long as the timeout limit, during which no faults are judged, so the processor can boot. It then starts watching again. A two-bit cause code and a fault flag report why the last reset happened.

The controller has four states:
- `ST_IDLE`: disabled.
- `ST_GRACE`: startup window.
- `ST_WATCH`: faults are judged.
- `ST_RESET`: the reset pulse is driven.

It has these transitions:
- `IDLE->GRACE` on enable.
- `GRACE->WATCH` when the window ends.
- `WATCH->RESET` on a timeout or a glitch.
- `RESET->GRACE` when the pulse ends with enable high.
- `RESET->IDLE` when the pulse ends with enable low.
- `GRACE->IDLE` and `WATCH->IDLE` when enable drops.

Top module: `hb_supervisor`

## Requirements
- R1: After power-on reset, `rst_n_o` is 1, `fault_o` is 0 and `cause_o` is 2'b00.
- R2: `hb_i` is synchronized by two flip-flops. Both its rising and its falling edges restart the interval counter, and each synchronized edge reaches the counter a fixed number of cycles after the input change.
- R3: In `ST_WATCH`, if no heartbeat edge arrives for more than `timeout_lim` cycles, the block pulses `rst_n_o` low and sets `cause_o` to 2'b01. The pulse begins between `timeout_lim` and `timeout_lim`+8 cycles after the last heartbeat change.
- R4: In `ST_WATCH`, an edge arriving fewer than `glitch_lim` cycles after the previous edge pulses `rst_n_o` low and sets `cause_o` to 2'b10. A spacing of exactly `glitch_lim` cycles is healthy. If a timeout and a glitch occur in the same cycle, the timeout takes priority.
- R5: The reset pulse holds `rst_n_o` low for exactly `rst_width` cycles. A value of 0 gives a one-cycle pulse.
- R6: After `rst_n_o` returns high, the block spends `timeout_lim` cycles in `ST_GRACE`, where glitches and timeouts cause no reset.
- R7: `cause_o` keeps its value after the pulse ends. A later fault overwrites it. `fault_o` is 1 exactly when `cause_o` is not 2'b00, and `cause_o` never has both bits set.
- R8: While `en` is 0, `rst_n_o` stays 1 whatever the heartbeat does, and `cause_o` reads 2'b00. A pulse already in progress completes first.
- R9: When `en` rises, a grace window passes before any fault can be declared. A dead heartbeat is therefore reported no earlier than `timeout_lim` cycles after enabling.
- R10: A heartbeat whose edge spacing always lies between `glitch_lim` and `timeout_lim` cycles never causes a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Asynchronous active-low power-on reset of the supervisor |
| en | input | 1 | Supervision enable |
| hb_i | input | 1 | Heartbeat line from the processor (asynchronous) |
| timeout_lim | input | CNT_W | Longest allowed edge spacing in cycles; also the grace length |
| glitch_lim | input | CNT_W | Shortest allowed edge spacing in cycles |
| rst_width | input | CNT_W | Reset pulse length in cycles (0 acts as 1) |
| rst_n_o | output | 1 | Active-low reset to the processor |
| fault_o | output | 1 | A fault cause is recorded |
| cause_o | output | 2 | 2'b01 timeout, 2'b10 short pulse, 2'b00 none |

## Verification
The assertions check these invariants on every cycle:
- The interval counter restarts on each edge and otherwise counts up by one.
- Every reset pulse lasts at least the programmed width.
- A falling reset always carries a recorded cause.
- The cause code is never two-hot.
- `ST_GRACE` never jumps straight to `ST_RESET`.
- `ST_IDLE` keeps the reset released and the cause clear.

Only the bench scenarios can show the rest. These cover the exact boundary between a healthy spacing and a glitch, the detection delay after the heartbeat dies, the grace window absorbing glitches after boot and after enabling, and cause retention and overwrite across several faults with randomized widths.

// File: rtl/hb_sup_pkg.sv
package hb_sup_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRACE = 2'd1,
        ST_WATCH = 2'd2,
        ST_RESET = 2'd3
    } sup_state_t;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'b00,
        CAUSE_TIMEOUT = 2'b01,
        CAUSE_SHORT   = 2'b10
    } cause_t;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic d_i,
    output logic edge_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    // R2: both heartbeat polarities produce an edge pulse
    assign edge_o = chain_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/hb_interval_timer.sv
module hb_interval_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             clr_i,
    input  logic             edge_i,
    input  logic [CNT_W-1:0] glitch_lim,
    output logic [CNT_W-1:0] cnt_o,
    output logic             short_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)              cnt_q <= '0;
        else if (clr_i)          cnt_q <= '0;
        else if (edge_i)         cnt_q <= '0;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        span    = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
        short_o = edge_i && !clr_i && (span < {1'b0, glitch_lim});
    end

    assign cnt_o = cnt_q;

    a_r2_restart_on_edge: assert property (@(posedge clk) disable iff (!por_n)
        (edge_i && !clr_i) |=> (cnt_o == '0));

    a_r3_counts_up: assert property (@(posedge clk) disable iff (!por_n)
        (!edge_i && !clr_i && cnt_o != CNT_MAX) |=> (cnt_o == $past(cnt_o) + 1'b1));

endmodule

// File: rtl/hb_sup_fsm.sv
module hb_sup_fsm
    import hb_sup_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             en,
    input  logic [CNT_W-1:0] timeout_lim,
    input  logic [CNT_W-1:0] rst_width,
    input  logic [CNT_W-1:0] interval_i,
    input  logic             short_i,
    output logic             clr_o,
    output logic             rst_n_o,
    output logic [1:0]       cause_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    sup_state_t       state_q, state_n;
    cause_t           cause_q, cause_n;
    logic [CNT_W-1:0] phase_q;
    logic [CNT_W-1:0] grace_last, width_last;
    logic             timeout_hit;

    always_comb begin
        grace_last  = (timeout_lim == '0) ? '0 : timeout_lim - 1'b1;
        width_last  = (rst_width   == '0) ? '0 : rst_width   - 1'b1;
        timeout_hit = (interval_i >= timeout_lim);
    end

    // next state and cause selection
    always_comb begin
        state_n = state_q;
        cause_n = cause_q;
        unique case (state_q)
            ST_IDLE:  if (en) state_n = ST_GRACE;
            ST_GRACE: begin
                if (!en)                       state_n = ST_IDLE;
                else if (phase_q >= grace_last) state_n = ST_WATCH;
            end
            ST_WATCH: begin
                if (!en) begin
                    state_n = ST_IDLE;
                end else if (timeout_hit) begin
                    state_n = ST_RESET;
                    cause_n = CAUSE_TIMEOUT;
                end else if (short_i) begin
                    state_n = ST_RESET;
                    cause_n = CAUSE_SHORT;
                end
            end
            ST_RESET: if (phase_q >= width_last) state_n = en ? ST_GRACE : ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
        if (state_n == ST_IDLE) cause_n = CAUSE_NONE;
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_IDLE;
            cause_q <= CAUSE_NONE;
            phase_q <= '0;
        end else begin
            state_q <= state_n;
            cause_q <= cause_n;
            if (state_n != state_q)     phase_q <= '0;
            else if (phase_q != CNT_MAX) phase_q <= phase_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        rst_n_o = (state_q != ST_RESET);
        clr_o   = (state_q == ST_IDLE) || (state_q == ST_RESET);
        cause_o = cause_q;
    end

    // checker: cycles spent low so far
    logic [CNT_W:0] low_run_q;
    logic [CNT_W:0] width_need;
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                 low_run_q <= '0;
        else if (state_q == ST_RESET) low_run_q <= low_run_q + 1'b1;
        else                        low_run_q <= '0;
    end
    assign width_need = (rst_width == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, rst_width};

    a_r5_min_width: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_RESET && state_n != ST_RESET) |-> (low_run_q + 1'b1 >= width_need));

    a_r3_fall_has_cause: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_n_o) |-> (cause_o != 2'b00));

    a_r7_cause_onehot: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(cause_o));

    a_r6_grace_no_reset: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_GRACE) |=> (state_q != ST_RESET));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_IDLE) |-> (rst_n_o && cause_o == 2'b00));

endmodule

// File: rtl/hb_supervisor.sv
module hb_supervisor #(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             en,
    input  logic             hb_i,
    input  logic [CNT_W-1:0] timeout_lim,
    input  logic [CNT_W-1:0] glitch_lim,
    input  logic [CNT_W-1:0] rst_width,
    output logic             rst_n_o,
    output logic             fault_o,
    output logic [1:0]       cause_o
);
    logic             hb_edge;
    logic             clr;
    logic             short_pulse;
    logic [CNT_W-1:0] interval;

    hb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .por_n  (por_n),
        .d_i    (hb_i),
        .edge_o (hb_edge)
    );

    hb_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .por_n      (por_n),
        .clr_i      (clr),
        .edge_i     (hb_edge),
        .glitch_lim (glitch_lim),
        .cnt_o      (interval),
        .short_o    (short_pulse)
    );

    hb_sup_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .por_n       (por_n),
        .en          (en),
        .timeout_lim (timeout_lim),
        .rst_width   (rst_width),
        .interval_i  (interval),
        .short_i     (short_pulse),
        .clr_o       (clr),
        .rst_n_o     (rst_n_o),
        .cause_o     (cause_o)
    );

    assign fault_o = (cause_o != 2'b00);

endmodule

// File: tb/hb_supervisor_bench.sv
module hb_supervisor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 24;
    localparam int T_LIM      = 400;
    localparam int G_LIM      = 20;

    logic             clk = 1'b0;
    logic             por_n = 1'b0;
    logic             en = 1'b0;
    logic             hb = 1'b0;
    logic [CNT_W-1:0] timeout_lim = CNT_W'(T_LIM);
    logic [CNT_W-1:0] glitch_lim  = CNT_W'(G_LIM);
    logic [CNT_W-1:0] rst_width   = CNT_W'(50);
    logic             rst_n;
    logic             fault;
    logic [1:0]       cause;

    int checks = 0, fails = 0;
    int cyc = 0, fall_cnt = 0, rise_cnt = 0, fall_cyc = 0, rise_cyc = 0, last_w = 0, last_tgl = 0;
    logic prev_rst = 1'b1;

    hb_supervisor #(.CNT_W(CNT_W)) u_hb_supervisor (
        .clk(clk), .por_n(por_n), .en(en), .hb_i(hb),
        .timeout_lim(timeout_lim), .glitch_lim(glitch_lim), .rst_width(rst_width),
        .rst_n_o(rst_n), .fault_o(fault), .cause_o(cause)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cyc++;
        if (prev_rst && !rst_n) begin fall_cnt++; fall_cyc = cyc; end
        if (!prev_rst && rst_n) begin rise_cnt++; rise_cyc = cyc; last_w = cyc - fall_cyc; end
        prev_rst = rst_n;
    end

    function automatic int exp_width(int w);
        return (w == 0) ? 1 : w;
    endfunction

    function automatic int exp_cause(bit is_short);
        return is_short ? 2 : 1;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic tgl(int w);
        repeat (w) tick();
        hb = ~hb;
        last_tgl = cyc;
    endtask

    task automatic healthy(int total);
        int spent = 0;
        while (spent < total) begin
            int w = $urandom_range(T_LIM - 100, 40);
            tgl(w);
            spent += w;
        end
    endtask

    task automatic wait_fall(int limit, output bit seen);
        int f0 = fall_cnt;
        seen = 0;
        for (int i = 0; i < limit; i++) begin
            tick();
            if (fall_cnt != f0) begin seen = 1; break; end
        end
    endtask

    task automatic wait_rise(int limit);
        for (int i = 0; i < limit; i++) begin
            if (rst_n) break;
            tick();
        end
    endtask

    initial begin
        repeat (190000) @(negedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        bit seen;
        int f0, t0;
        void'($urandom(32'd20240611));
        repeat (4) tick();
        // R1 reset state
        chk(rst_n == 1'b1, "R1 rst_n", int'(rst_n), 1);
        chk(fault == 1'b0, "R1 fault", int'(fault), 0);
        chk(cause == 2'b00, "R1 cause", int'(cause), 0);
        por_n = 1'b1;
        tick();

        // R8: disabled, dead heartbeat -> nothing
        f0 = fall_cnt;
        repeat (1500) tick();
        chk(fall_cnt == f0, "R8 disabled no reset", fall_cnt - f0, 0);

        // R10/R9: enable with healthy heartbeat
        en = 1'b1;
        f0 = fall_cnt;
        healthy(4000);
        chk(fall_cnt == f0, "R10 healthy no reset", fall_cnt - f0, 0);
        chk(cause == 2'b00, "R10 cause clear", int'(cause), 0);

        // R3: heartbeat dies
        t0 = last_tgl;
        wait_fall(3 * T_LIM, seen);
        chk(seen, "R3 timeout reset seen", int'(seen), 1);
        chk((fall_cyc - t0 >= T_LIM) && (fall_cyc - t0 <= T_LIM + 8), "R3 detect delay", fall_cyc - t0, T_LIM);
        chk(cause == 2'd1, "R3 cause", int'(cause), exp_cause(0));
        wait_rise(200);
        tick();
        chk(last_w == exp_width(50), "R5 width", last_w, exp_width(50));
        chk(fault == 1'b1, "R7 fault held", int'(fault), 1);

        // R6: still dead -> next reset no earlier than one grace window
        wait_fall(3 * T_LIM, seen);
        chk(seen && (fall_cyc - rise_cyc >= T_LIM) && (fall_cyc - rise_cyc <= T_LIM + 4),
            "R6 grace before timeout", fall_cyc - rise_cyc, T_LIM + 1);
        wait_rise(200);

        // R6: glitches during grace are ignored
        f0 = fall_cnt;
        for (int i = 0; i < 10; i++) tgl(3);
        healthy(2000);
        chk(fall_cnt == f0, "R6 grace glitches ignored", fall_cnt - f0, 0);
        chk(cause == 2'd1, "R7 cause retained", int'(cause), 1);

        // R4 boundary: spacing G_LIM is healthy, G_LIM-1 is a glitch
        f0 = fall_cnt;
        tgl(G_LIM);
        repeat (G_LIM - 2) tick();
        chk(fall_cnt == f0, "R4 spacing equal limit healthy", fall_cnt - f0, 0);
        tick();
        hb = ~hb;
        repeat (8) tick();
        chk(fall_cnt == f0 + 1, "R4 short pulse reset", fall_cnt - f0, 1);
        chk(cause == 2'd2, "R4/R7 cause overwritten", int'(cause), exp_cause(1));
        wait_rise(200);
        tick();

        // R2: falling-edge-only spacing also timed (hb now at some level; two quick edges)
        healthy(1500);
        f0 = fall_cnt;
        tgl(5);
        repeat (8) tick();
        chk(fall_cnt == f0 + 1, "R2 either polarity timed", fall_cnt - f0, 1);
        wait_rise(200);

        // randomized rounds: width and fault kind
        for (int r = 0; r < 8; r++) begin
            int w;
            bit is_short;
            w = (r == 0) ? 0 : $urandom_range(80, 0);
            is_short = $urandom_range(1, 0);
            rst_width = CNT_W'(w);
            healthy(1200);
            if (is_short) tgl(4);
            wait_fall(3 * T_LIM, seen);
            chk(seen, "R3/R4 random fault seen", int'(seen), 1);
            chk(int'(cause) == exp_cause(is_short), "R7 random cause", int'(cause), exp_cause(is_short));
            wait_rise(200);
            tick();
            chk(last_w == exp_width(w), "R5 random width", last_w, exp_width(w));
        end

        // R8: disable clears cause, dead heartbeat ignored
        en = 1'b0;
        repeat (5) tick();
        chk(cause == 2'b00 && fault == 1'b0, "R8 cause cleared", int'(cause), 0);
        f0 = fall_cnt;
        repeat (1500) tick();
        chk(fall_cnt == f0 && rst_n, "R8 no reset while disabled", fall_cnt - f0, 0);

        // R9: enable with dead heartbeat -> grace first
        en = 1'b1;
        t0 = cyc;
        wait_fall(3 * T_LIM, seen);
        chk(seen && (fall_cyc - t0 >= T_LIM) && (fall_cyc - t0 <= T_LIM + 6),
            "R9 grace after enable", fall_cyc - t0, T_LIM + 2);
        wait_rise(200);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule